// File: doc/BRIEF.md
# Out-of-order issue and result-bus scheduler (timing model)

This block is a cycle-accurate timing model of a dynamically scheduled floating-point engine with register renaming. It accepts at most one decoded instruction per cycle: an operation class, a destination register and two source registers. The instruction is given a free reservation station belonging to its functional unit, and its destination register is renamed to that station's tag. The station waits until both operands are available, starts on its unit when the unit is idle, optionally spends one memory cycle, and then competes for a single shared result bus.

No data values are carried. The block only produces timing. When an instruction writes the result bus, the block reports its sequence number and class, together with the cycle numbers of its issue, execution start, memory access (zero if it has none) and result-bus write. A cycle counter reads 1 in the first cycle after reset.

Each station is a small state machine with these states: FREE, WAIT (operands outstanding or unit busy), EXEC (remaining execution cycles), MEM (load memory cycle) and BUS (result waiting for the bus). The transitions are:
- FREE→WAIT on allocation.
- WAIT→EXEC on dispatch with latency above 1. With latency 1, dispatch goes directly to MEM for a load or to BUS otherwise.
- EXEC→MEM for a load, or EXEC→BUS otherwise, after the last execution cycle.
- MEM→BUS always.
- BUS→FREE on a bus grant.

Top module: `tomasulo_sched`

## Requirements
- R1: Instructions issue in program order, at most one per cycle. `in_ready` is high exactly when a FREE station exists for the unit of `in_cls`, and the issue cycle is the cycle in which `in_valid` and `in_ready` are both high. Class encoding: 0 integer, 1 load, 2 FP add, 3 FP multiply.
- R2: The integer/address unit serves classes 0 and 1 and has 5 stations. The FP adder has 3 stations and the FP multiplier has 2. When all stations of a unit are taken, issue stalls.
- R3: Latencies are 1 cycle for integer/address, 4 for the adder and 15 for the multiplier. Each unit is not pipelined, so a new operation may start on a unit only in the cycle after the previous one's last execution cycle.
- R4: A load executes, then accesses memory in the cycle after its last execution cycle, and requests the bus in the following cycle. Other classes request the bus in the cycle after execution ends and report a memory cycle of 0. A load issued in cycle 1 executes in cycle 2, accesses memory in cycle 3 and writes the bus in cycle 4.
- R5: An instruction starts executing no earlier than the cycle after its issue. It also starts no earlier than the cycle after the bus write of its last outstanding source operand.
- R6: At most one result is written on the bus per cycle. When several are waiting, the one issued earliest wins and the others keep waiting.
- R7: Each register maps to the most recently issued pending writer. A mapping is cleared only when that same tag is broadcast, so a consumer waits for the latest writer.
- R8: A station becomes available for a new issue in the cycle after its bus write.
- R9: In the first cycle after reset the counter reads 1, no result is reported, and `in_ready` is high.
- R10: When several ready stations wait for the same idle unit, the one issued earliest starts first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_cls | input | 2 | Operation class (0 int, 1 load, 2 FP add, 3 FP mul) |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_ready | output | 1 | A station is free for this class |
| done_valid | output | 1 | A result is on the bus this cycle |
| done_seq | output | 16 | Issue sequence number of the result |
| done_cls | output | 2 | Class of the result |
| done_issue | output | 16 | Issue cycle |
| done_exec | output | 16 | Execution start cycle |
| done_mem | output | 16 | Memory cycle, 0 if none |
| done_cdb | output | 16 | Bus write cycle |

## Verification
The bench uses the default parameters: 5/3/2 stations with latencies of 1/4/15 cycles. With these values, a multiply stall on a full station set and a back-to-back multiply wait on a busy unit both occur within about fifty cycles. With the same values, bus collisions between a 4-cycle add and a load that ends at the same time can be arranged exactly. A behavioural schedule that works per instruction is checked against the outputs on every cycle. This covers directed streams for renaming, bus contention and oldest-first dispatch, and three iterations of a multiply-add loop.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
    typedef enum logic [1:0] {
        OP_INT  = 2'd0,
        OP_LOAD = 2'd1,
        OP_FADD = 2'd2,
        OP_FMUL = 2'd3
    } op_cls_e;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_WAIT,
        ST_EXEC,
        ST_MEM,
        ST_BUS
    } st_e;
endpackage

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int N  = 4,
    parameter int SW = 16
) (
    input  logic [N-1:0]    req,
    input  logic [N*SW-1:0] seqs,
    output logic [N-1:0]    grant
);
    logic          found;
    logic [SW-1:0] best;

    always_comb begin
        grant = '0;
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || seqs[i*SW +: SW] < best)) begin
                found    = 1'b1;
                best     = seqs[i*SW +: SW];
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import tsched_pkg::*;
#(
    parameter int SW      = 16,
    parameter int CW      = 16,
    parameter int TW      = 4,
    parameter int INT_LAT = 1,
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  op_cls_e       a_cls,
    input  logic [SW-1:0] a_seq,
    input  logic          a_q1v,
    input  logic [TW-1:0] a_q1t,
    input  logic          a_q2v,
    input  logic [TW-1:0] a_q2t,
    input  logic [CW-1:0] now,
    input  logic          dispatch,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic          cdb_grant,
    output logic          busy,
    output logic          ready,
    output logic          executing,
    output logic          cdb_req,
    output logic [SW-1:0] seq,
    output op_cls_e       cls,
    output logic [CW-1:0] t_issue,
    output logic [CW-1:0] t_exec,
    output logic [CW-1:0] t_mem
);
    localparam int MAXL = (MUL_LAT > ADD_LAT) ? ((MUL_LAT > INT_LAT) ? MUL_LAT : INT_LAT)
                                              : ((ADD_LAT > INT_LAT) ? ADD_LAT : INT_LAT);
    localparam int KW = $clog2(MAXL + 1);

    st_e           state, state_nx;
    op_cls_e       cls_q;
    logic [SW-1:0] seq_q;
    logic          q1v, q2v;
    logic [TW-1:0] q1t, q2t;
    logic [KW-1:0] cnt;
    logic [KW-1:0] lat;
    logic          is_load;
    st_e           after_exec;

    function automatic logic [KW-1:0] lat_of(op_cls_e c);
        case (c)
            OP_INT, OP_LOAD: lat_of = KW'(INT_LAT);
            OP_FADD:         lat_of = KW'(ADD_LAT);
            default:         lat_of = KW'(MUL_LAT);
        endcase
    endfunction

    assign lat        = lat_of(cls_q);
    assign is_load    = (cls_q == OP_LOAD);
    assign after_exec = is_load ? ST_MEM : ST_BUS;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FREE: if (alloc)     state_nx = ST_WAIT;
            ST_WAIT: if (dispatch)  state_nx = (lat > KW'(1)) ? ST_EXEC : after_exec;
            ST_EXEC: if (cnt == KW'(1)) state_nx = after_exec;
            ST_MEM:                 state_nx = ST_BUS;
            ST_BUS:  if (cdb_grant) state_nx = ST_FREE;
            default:                state_nx = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q   <= OP_INT;
            seq_q   <= '0;
            q1v     <= 1'b0;
            q2v     <= 1'b0;
            q1t     <= '0;
            q2t     <= '0;
            cnt     <= '0;
            t_issue <= '0;
            t_exec  <= '0;
            t_mem   <= '0;
        end else begin
            if (alloc) begin
                cls_q   <= a_cls;
                seq_q   <= a_seq;
                q1v     <= a_q1v;
                q1t     <= a_q1t;
                q2v     <= a_q2v;
                q2t     <= a_q2t;
                t_issue <= now;
                t_exec  <= '0;
                t_mem   <= '0;
            end
            if (state == ST_WAIT && cdb_valid) begin
                if (q1v && q1t == cdb_tag) q1v <= 1'b0;
                if (q2v && q2t == cdb_tag) q2v <= 1'b0;
            end
            if (dispatch) begin
                t_exec <= now;
                cnt    <= lat - KW'(1);
            end
            if (state == ST_EXEC) cnt <= cnt - KW'(1);
            if (state == ST_MEM)  t_mem <= now;
        end
    end

    assign busy      = (state != ST_FREE);
    assign ready     = (state == ST_WAIT) && !q1v && !q2v;
    assign executing = (state == ST_EXEC);
    assign cdb_req   = (state == ST_BUS);
    assign seq       = seq_q;
    assign cls       = cls_q;

    // R5: the picker may only start a station whose operands are all present
    a_r5_start_needs_operands: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> (state == ST_WAIT && !q1v && !q2v));

    // R4: a load's memory cycle directly follows its last execution cycle
    a_r4_load_mem_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_req && is_load) |-> (t_mem == t_exec + CW'(lat)));

    // R6: a waiting result keeps its place until granted
    a_r6_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_req && !cdb_grant) |=> cdb_req);
endmodule

// File: rtl/tomasulo_sched.sv
module tomasulo_sched
    import tsched_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int INT_RS  = 5,
    parameter int ADD_RS  = 3,
    parameter int MUL_RS  = 2,
    parameter int INT_LAT = 1,
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 15,
    parameter int CW      = 16,
    parameter int SW      = 16,
    localparam int RW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_cls,
    input  logic [RW-1:0] in_dst,
    input  logic [RW-1:0] in_src1,
    input  logic [RW-1:0] in_src2,
    output logic          in_ready,
    output logic          done_valid,
    output logic [SW-1:0] done_seq,
    output logic [1:0]    done_cls,
    output logic [CW-1:0] done_issue,
    output logic [CW-1:0] done_exec,
    output logic [CW-1:0] done_mem,
    output logic [CW-1:0] done_cdb
);
    localparam int NRS      = INT_RS + ADD_RS + MUL_RS;
    localparam int TW       = $clog2(NRS);
    localparam int ADD_BASE = INT_RS;
    localparam int MUL_BASE = INT_RS + ADD_RS;

    function automatic logic [1:0] unit_of_cls(op_cls_e c);
        case (c)
            OP_INT, OP_LOAD: unit_of_cls = 2'd0;
            OP_FADD:         unit_of_cls = 2'd1;
            default:         unit_of_cls = 2'd2;
        endcase
    endfunction

    function automatic logic [1:0] unit_of_rs(int i);
        if (i < ADD_BASE)      unit_of_rs = 2'd0;
        else if (i < MUL_BASE) unit_of_rs = 2'd1;
        else                   unit_of_rs = 2'd2;
    endfunction

    logic [CW-1:0]    cyc;
    logic [SW-1:0]    seq_ctr;
    logic [NRS-1:0]   st_busy, st_ready, st_exec, st_req, disp, cdb_grant, alloc_vec;
    logic [NRS*SW-1:0] st_seq;
    op_cls_e          st_cls  [NRS];
    logic [CW-1:0]    st_tiss [NRS];
    logic [CW-1:0]    st_texe [NRS];
    logic [CW-1:0]    st_tmem [NRS];
    logic [NREG-1:0]  map_v;
    logic [TW-1:0]    map_tag [NREG];
    logic [1:0]       in_unit;
    logic             alloc_ok, fire, cdb_valid;
    logic [TW-1:0]    alloc_idx, cdb_tag;
    logic             q1v, q2v;

    assign in_unit = unit_of_cls(op_cls_e'(in_cls));

    always_comb begin
        alloc_ok  = 1'b0;
        alloc_idx = '0;
        for (int i = 0; i < NRS; i++) begin
            if (!alloc_ok && !st_busy[i] && unit_of_rs(i) == in_unit) begin
                alloc_ok  = 1'b1;
                alloc_idx = TW'(i);
            end
        end
    end

    assign in_ready  = alloc_ok;
    assign fire      = in_valid && alloc_ok;
    assign alloc_vec = fire ? (NRS'(1) << alloc_idx) : '0;
    assign q1v = map_v[in_src1] && !(cdb_valid && map_tag[in_src1] == cdb_tag);
    assign q2v = map_v[in_src2] && !(cdb_valid && map_tag[in_src2] == cdb_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc     <= CW'(1);
            seq_ctr <= '0;
        end else begin
            cyc <= cyc + CW'(1);
            if (fire) seq_ctr <= seq_ctr + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_v <= '0;
            for (int r = 0; r < NREG; r++) map_tag[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++)
                if (cdb_valid && map_v[r] && map_tag[r] == cdb_tag) map_v[r] <= 1'b0;
            if (fire) begin
                map_v[in_dst]   <= 1'b1;
                map_tag[in_dst] <= alloc_idx;
            end
        end
    end

    for (genvar g = 0; g < NRS; g++) begin : g_rs
        rs_entry #(.SW(SW), .CW(CW), .TW(TW), .INT_LAT(INT_LAT),
                   .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_rs (
            .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
            .a_cls(op_cls_e'(in_cls)), .a_seq(seq_ctr),
            .a_q1v(q1v), .a_q1t(map_tag[in_src1]),
            .a_q2v(q2v), .a_q2t(map_tag[in_src2]),
            .now(cyc), .dispatch(disp[g]),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_grant(cdb_grant[g]),
            .busy(st_busy[g]), .ready(st_ready[g]), .executing(st_exec[g]),
            .cdb_req(st_req[g]), .seq(st_seq[g*SW +: SW]), .cls(st_cls[g]),
            .t_issue(st_tiss[g]), .t_exec(st_texe[g]), .t_mem(st_tmem[g])
        );
    end

    for (genvar u = 0; u < 3; u++) begin : g_unit
        localparam int BASE = (u == 0) ? 0 : (u == 1) ? ADD_BASE : MUL_BASE;
        localparam int SIZE = (u == 0) ? INT_RS : (u == 1) ? ADD_RS : MUL_RS;
        logic            unit_busy;
        logic [SIZE-1:0] req_u, gnt_u;
        assign unit_busy = |st_exec[BASE +: SIZE];
        assign req_u     = st_ready[BASE +: SIZE] & {SIZE{!unit_busy}};
        rs_oldest_pick #(.N(SIZE), .SW(SW)) u_pick (
            .req(req_u), .seqs(st_seq[BASE*SW +: SIZE*SW]), .grant(gnt_u)
        );
        assign disp[BASE +: SIZE] = gnt_u;

        // R3: one operation at a time on each unit
        a_r3_unit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({st_exec[BASE +: SIZE], gnt_u}) <= 1);
    end

    rs_oldest_pick #(.N(NRS), .SW(SW)) u_bus_pick (
        .req(st_req), .seqs(st_seq), .grant(cdb_grant)
    );

    always_comb begin
        cdb_valid  = |cdb_grant;
        cdb_tag    = '0;
        done_seq   = '0;
        done_cls   = '0;
        done_issue = '0;
        done_exec  = '0;
        done_mem   = '0;
        for (int i = 0; i < NRS; i++) begin
            if (cdb_grant[i]) begin
                cdb_tag    = TW'(i);
                done_seq   = st_seq[i*SW +: SW];
                done_cls   = st_cls[i];
                done_issue = st_tiss[i];
                done_exec  = st_texe[i];
                done_mem   = st_tmem[i];
            end
        end
    end

    assign done_valid = cdb_valid;
    assign done_cdb   = cyc;

    // R6: a single result bus
    a_r6_one_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cdb_grant));

    // R9: the cycle number advances by one every clock after reset
    a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cyc == $past(cyc) + CW'(1)));

    for (genvar r = 0; r < NREG; r++) begin : g_map_chk
        // R7: a pending mapping always names a live station
        a_r7_map_live: assert property (@(posedge clk) disable iff (!rst_n)
            map_v[r] |-> st_busy[map_tag[r]]);
    end
endmodule

// File: tb/tomasulo_sched_test.sv
module tomasulo_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_cls = '0;
    logic [3:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic        in_ready, done_valid;
    logic [15:0] done_seq, done_issue, done_exec, done_mem, done_cdb;
    logic [1:0]  done_cls;

    tomasulo_sched uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ready(in_ready), .done_valid(done_valid), .done_seq(done_seq),
        .done_cls(done_cls), .done_issue(done_issue), .done_exec(done_exec),
        .done_mem(done_mem), .done_cdb(done_cdb)
    );

    always #5 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    int np;
    int p_cls[64], p_dst[64], p_s1[64], p_s2[64], pr1[64], pr2[64];
    int m_iss[64], m_exe[64], m_mem[64], m_cdb[64];
    int o_iss[64], o_exe[64], o_mem[64], o_cdb[64];

    function automatic int unit_of(int c); return (c <= 1) ? 0 : (c == 2) ? 1 : 2; endfunction
    function automatic int lat_of(int u);  return (u == 0) ? 1 : (u == 1) ? 4 : 15; endfunction
    function automatic int cap_of(int u);  return (u == 0) ? 5 : (u == 1) ? 3 : 2; endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_inst(int c, int d, int a, int b);
        p_cls[np] = c; p_dst[np] = d; p_s1[np] = a; p_s2[np] = b; np++;
    endtask

    function automatic bit avail(int p, int c);
        return (p < 0) || (m_cdb[p] >= 0 && m_cdb[p] < c);
    endfunction

    task automatic build_model();
        int k = 0;
        int ndone = 0;
        for (int i = 0; i < np; i++) begin
            m_iss[i] = -1; m_exe[i] = -1; m_mem[i] = 0; m_cdb[i] = -1;
            o_iss[i] = -1; o_exe[i] = -1; o_mem[i] = -1; o_cdb[i] = -1;
            pr1[i] = -1; pr2[i] = -1;
            for (int j = 0; j < i; j++) begin
                if (p_dst[j] == p_s1[i]) pr1[i] = j;
                if (p_dst[j] == p_s2[i]) pr2[i] = j;
            end
        end
        for (int c = 1; c < 3000 && ndone < np; c++) begin
            for (int i = 0; i < np; i++) begin
                if (m_exe[i] >= 0 && m_cdb[i] < 0 &&
                    m_exe[i] + lat_of(unit_of(p_cls[i])) + (p_cls[i] == 1 ? 1 : 0) <= c) begin
                    m_cdb[i] = c; ndone++;
                    break;
                end
            end
            for (int u = 0; u < 3; u++) begin
                bit busy = 0;
                for (int i = 0; i < np; i++)
                    if (unit_of(p_cls[i]) == u && m_exe[i] >= 0 && m_exe[i] < c &&
                        m_exe[i] + lat_of(u) - 1 >= c) busy = 1;
                if (!busy) begin
                    for (int i = 0; i < np; i++) begin
                        if (unit_of(p_cls[i]) == u && m_iss[i] >= 0 && m_iss[i] < c &&
                            m_exe[i] < 0 && avail(pr1[i], c) && avail(pr2[i], c)) begin
                            m_exe[i] = c;
                            if (p_cls[i] == 1) m_mem[i] = c + lat_of(u);
                            break;
                        end
                    end
                end
            end
            if (k < np) begin
                int occ = 0;
                for (int i = 0; i < k; i++)
                    if (unit_of(p_cls[i]) == unit_of(p_cls[k]) &&
                        !(m_cdb[i] >= 0 && m_cdb[i] < c)) occ++;
                if (occ < cap_of(unit_of(p_cls[k]))) begin
                    m_iss[k] = c; k++;
                end
            end
        end
    endtask

    task automatic run_prog();
        int idx = 0;
        int last = 0;
        build_model();
        for (int i = 0; i < np; i++) if (m_cdb[i] > last) last = m_cdb[i];
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cur = 1; cur <= last + 2; cur++) begin
            int j = -1;
            in_valid = (idx < np);
            if (idx < np) begin
                in_cls = 2'(p_cls[idx]); in_dst = 4'(p_dst[idx]);
                in_src1 = 4'(p_s1[idx]); in_src2 = 4'(p_s2[idx]);
            end
            #1;
            if (cur == 1) begin
                check(done_valid == 1'b0, "R9", "done_valid after reset", int'(done_valid), 0);
                check(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
            end
            if (idx < np)
                check(in_ready == (m_iss[idx] == cur), "R1", "in_ready",
                      int'(in_ready), int'(m_iss[idx] == cur));
            for (int i = 0; i < np; i++) if (m_cdb[i] == cur) j = i;
            check(done_valid == (j >= 0), "R6", "done_valid", int'(done_valid), int'(j >= 0));
            if (j >= 0 && done_valid) begin
                check(int'(done_seq) == j, "R6", "done_seq", int'(done_seq), j);
                check(int'(done_issue) == m_iss[j], "R1", "issue stamp", int'(done_issue), m_iss[j]);
                check(int'(done_exec) == m_exe[j], "R5", "exec stamp", int'(done_exec), m_exe[j]);
                check(int'(done_mem) == m_mem[j], "R4", "mem stamp", int'(done_mem), m_mem[j]);
                check(int'(done_cdb) == cur, "R6", "bus stamp", int'(done_cdb), cur);
            end
            if (done_valid && int'(done_seq) < np) begin
                o_iss[done_seq] = int'(done_issue); o_exe[done_seq] = int'(done_exec);
                o_mem[done_seq] = int'(done_mem);   o_cdb[done_seq] = int'(done_cdb);
            end
            @(posedge clk);
            if (in_valid && in_ready) idx++;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic expect_t(int s, int iss, int exe, int mem, int cdb, string req);
        check(o_iss[s] == iss, req, "hand issue", o_iss[s], iss);
        check(o_exe[s] == exe, req, "hand exec", o_exe[s], exe);
        check(o_mem[s] == mem, req, "hand mem", o_mem[s], mem);
        check(o_cdb[s] == cdb, req, "hand bus", o_cdb[s], cdb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R4 and R5: load then dependent add
        np = 0;
        add_inst(1, 2, 9, 9);
        add_inst(2, 4, 2, 0);
        run_prog();
        expect_t(0, 1, 2, 3, 4, "R4");
        expect_t(1, 2, 5, 0, 9, "R5");

        // R2, R3, R8: three independent multiplies against two stations
        np = 0;
        add_inst(3, 1, 0, 0);
        add_inst(3, 2, 0, 0);
        add_inst(3, 3, 0, 0);
        run_prog();
        expect_t(0, 1, 2, 0, 17, "R3");
        expect_t(1, 2, 17, 0, 32, "R3");
        expect_t(2, 18, 32, 0, 47, "R2");
        check(o_iss[2] == o_cdb[0] + 1, "R8", "reuse after bus write", o_iss[2], o_cdb[0] + 1);

        // R7: consumer follows the latest writer of a renamed register
        np = 0;
        add_inst(2, 1, 0, 0);
        add_inst(3, 1, 0, 0);
        add_inst(2, 2, 1, 0);
        run_prog();
        expect_t(0, 1, 2, 0, 6, "R7");
        check(o_exe[2] == 19, "R7", "waits for latest writer", o_exe[2], 19);

        // R6 and R10: bus collisions and oldest-first start
        np = 0;
        add_inst(2, 1, 0, 0);
        add_inst(0, 5, 0, 0);
        add_inst(1, 6, 0, 0);
        add_inst(1, 7, 0, 0);
        add_inst(2, 8, 7, 7);
        add_inst(2, 9, 7, 0);
        run_prog();
        check(o_cdb[0] == 6, "R6", "older add wins bus", o_cdb[0], 6);
        check(o_cdb[2] == 7, "R6", "load deferred", o_cdb[2], 7);
        check(o_cdb[3] == 8, "R6", "second load deferred", o_cdb[3], 8);
        check(o_exe[4] == 9, "R10", "older waiting add first", o_exe[4], 9);
        check(o_exe[5] == 13, "R10", "younger add after unit frees", o_exe[5], 13);

        // multiply-add loop, three iterations, compared cycle by cycle
        np = 0;
        for (int it = 0; it < 3; it++) begin
            add_inst(1, 2, 10, 10);
            add_inst(3, 4, 2, 0);
            add_inst(1, 6, 11, 11);
            add_inst(2, 6, 4, 6);
            add_inst(0, 10, 10, 10);
            add_inst(0, 11, 11, 11);
            add_inst(0, 12, 12, 12);
        end
        run_prog();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule